// File: doc/BRIEF.md
# Grouped Power-Rail Sequencer

This block powers up the supply rails of a module one group at a time. Each rail has an enable output. Most rails also report back on a power-good input. A group is switched on only when every monitored power-good line of all lower groups is high. When the last group is good, the block raises an all-good flag. Each group has its own fast-discharge output. That output holds the group's rails discharged whenever the group is off. It is released one cycle before the group is enabled.

The rails are shut down in reverse group order in three cases: the start request drops, a group fails to report good within a timeout, or a monitored rail is lost after power-up. For each group the enables are removed first and its discharge is applied in the next cycle. A timeout or a lost rail sets a fault flag. The fault flag is sticky: until reset the block ignores further start requests. This flag is intended for status-LED logic.

Rail-to-group and power-good-to-group assignments are parameters. The defaults describe four groups:
- Group 0: the 0.9 V core rail.
- Group 1: the 0.95 V rail.
- Group 2: the 1.8 V rail.
- Group 3: the 1.8 V I/O, 1.35 V, memory termination and adjustable rails, plus the two carrier-board rails.

Top module: `rail_sequencer`

## Requirements
- R1: After reset, every rail enable is 0, every discharge output is 1, and `fault_o` and `all_good_o` are 0.
- R2: Start is sampled high at a clock edge. At that same edge `dischg_o[0]` goes low, and `rail_en_o[0]` goes high one edge later.
- R3: Group g+1 is never enabled before group g. Its discharge is released at the first edge at which all power-good lines of groups 0..g are high. Rail mapping (rail_en_o bit → group): 0→0 (0.9 V), 1→1 (0.95 V), 2→2 (1.8 V), 3..8→3. Bits 3..8 are the 1.8 V I/O, 1.35 V, termination, adjustable, carrier 3.3 V and carrier 1.8 V rails. All six rise at the same edge.
- R4: A group's discharge output is released exactly one cycle before its enables rise. Enable and discharge of a group are never high together.
- R5: The termination rail (bit 5) has no power-good input. Group 3 completes on power-good bits 3..7 alone. Power-good mapping (pg_i bit → rail): 0→0.9 V, 1→0.95 V, 2→1.8 V, 3→1.8 V I/O, 4→1.35 V, 5→adjustable, 6→carrier 3.3 V, 7→carrier 1.8 V.
- R6: Carrier power-good bits 6 and 7 held high, as with no carrier present, do not hold up group 3.
- R7: A group is enabled at edge c. If its power-good lines are still not all high at edge c+TIMEOUT_CYC, `fault_o` rises at that edge and shutdown starts. Lines that are all high at edge c+TIMEOUT_CYC count as success.
- R8: After all-good, a monitored power-good line seen low at edge d sets `fault_o` and clears `all_good_o` at edge d. Shutdown follows.
- R9: Shutdown begins at edge s. The highest enabled group k loses its enables at s+1 and gets discharge at s+2. Group k-1 loses its enables at s+3, and so on down to group 0.
- R10: Start sampled low while powering up or powered up gives the same reverse shutdown without a fault. A later start repeats the power-up.
- R11: `fault_o` stays high until reset. While it is set, all rails stay off and discharged whatever start does.
- R12: `all_good_o` is high only while every group is enabled. It rises at the edge where the last group's power-good lines are first seen all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Power-up request, level |
| pg_i | input | NUM_PG | Power-good lines |
| rail_en_o | output | NUM_RAILS | Rail enables |
| dischg_o | output | NUM_GROUPS | Fast-discharge controls, one per group |
| fault_o | output | 1 | Sticky fault flag |
| all_good_o | output | 1 | All groups up and good |

## Verification
Power-up is run with two different sets of per-rail power-good delays. The gap before each group's discharge release must follow the slowest line of the previous group, not a fixed step. This separates true gating from a timed sequence, and shows that the termination rail is left out. A power-good delay equal to the timeout and one cycle longer separates the two sides of the timeout boundary. Carrier lines that are held high show that an absent carrier is treated as good. A power-good line that drops after power-up and a start that drops after power-up both trigger shutdown. The two runs are told apart by the fault flag, while both must show the same two-cycle-per-group reverse order.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
   // width of one entry in a group map parameter
   localparam int MAP_FIELD_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ARM,
      ST_WAIT,
      ST_DONE,
      ST_OFF,
      ST_DIS,
      ST_HALT
   } seq_state_e;
endpackage

// File: rtl/rseq_pg_eval.sv
module rseq_pg_eval
   import rseq_pkg::*;
#(
   parameter int NUM_GROUPS = 4,
   parameter int NUM_PG     = 8,
   parameter logic [NUM_PG*MAP_FIELD_W-1:0] PG_MAP = '0
) (
   input  logic [NUM_PG-1:0]     pg_i,
   output logic [NUM_GROUPS-1:0] grp_ok_o
);
   localparam int W = MAP_FIELD_W;

   for (genvar i = 0; i < NUM_PG; i++) begin : g_map_chk
      if (int'(PG_MAP[i*W +: W]) >= NUM_GROUPS) begin : g_bad
         $error("power-good map entry names a group that does not exist");
      end
   end

   // a group with no monitored line reads as good
   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      logic ok;
      always_comb begin
         ok = 1'b1;
         for (int i = 0; i < NUM_PG; i++) begin
            if (int'(PG_MAP[i*W +: W]) == g && !pg_i[i]) ok = 1'b0;
         end
      end
      assign grp_ok_o[g] = ok;
   end
endmodule

// File: rtl/rseq_timer.sv
module rseq_timer #(
   parameter int TIMEOUT_CYC = 1_250_000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   input  logic run_i,
   output logic expired_o
);
   localparam int CW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
   localparam logic [CW-1:0] LIM = CW'(TIMEOUT_CYC - 1);

   if (TIMEOUT_CYC < 2) begin : g_bad
      $error("TIMEOUT_CYC must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   cnt_q <= '0;
      else if (clr_i)                cnt_q <= '0;
      else if (run_i && cnt_q != LIM) cnt_q <= cnt_q + CW'(1);
   end

   assign expired_o = run_i && (cnt_q == LIM);

   // R7: the count never passes the limit
   a_r7_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= LIM) else $error("R7 timer count beyond limit");
endmodule

// File: rtl/rseq_rail_map.sv
module rseq_rail_map
   import rseq_pkg::*;
#(
   parameter int NUM_GROUPS = 4,
   parameter int NUM_RAILS  = 9,
   parameter logic [NUM_RAILS*MAP_FIELD_W-1:0] RAIL_MAP = '0
) (
   input  logic [NUM_GROUPS-1:0] grp_on_i,
   output logic [NUM_RAILS-1:0]  rail_en_o
);
   localparam int W = MAP_FIELD_W;

   for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
      localparam int G = int'(RAIL_MAP[i*W +: W]);
      if (G >= NUM_GROUPS) begin : g_bad
         $error("rail map entry names a group that does not exist");
      end else begin : g_ok
         assign rail_en_o[i] = grp_on_i[G];
      end
   end
endmodule

// File: rtl/rseq_ctrl.sv
module rseq_ctrl
   import rseq_pkg::*;
#(
   parameter int NUM_GROUPS = 4
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  start_i,
   input  logic [NUM_GROUPS-1:0] grp_ok_i,
   input  logic                  tmo_i,
   output logic [NUM_GROUPS-1:0] grp_on_o,
   output logic [NUM_GROUPS-1:0] dis_o,
   output logic                  fault_o,
   output logic                  all_good_o,
   output logic                  tmr_clr_o,
   output logic                  tmr_run_o
);
   localparam int GW = (NUM_GROUPS > 2) ? $clog2(NUM_GROUPS) : 1;
   localparam logic [GW-1:0] LAST = GW'(NUM_GROUPS - 1);

   if (NUM_GROUPS < 2) begin : g_bad
      $error("NUM_GROUPS must be at least 2");
   end

   seq_state_e            state_q;
   logic [GW-1:0]         idx_q, nxt;
   logic [NUM_GROUPS-1:0] on_q, dis_q;
   logic                  err_q, lower_ok;

   assign nxt = idx_q + GW'(1);

   // every group below the current one still good
   always_comb begin
      lower_ok = 1'b1;
      for (int j = 0; j < NUM_GROUPS; j++) begin
         if (j < int'(idx_q) && !grp_ok_i[j]) lower_ok = 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         on_q    <= '0;
         dis_q   <= '1;
         err_q   <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: if (start_i) begin
               dis_q[0] <= 1'b0;
               idx_q    <= '0;
               state_q  <= ST_ARM;
            end
            ST_ARM: begin
               on_q[idx_q] <= 1'b1;
               state_q     <= ST_WAIT;
            end
            ST_WAIT: begin
               if (!lower_ok) begin
                  err_q   <= 1'b1;
                  state_q <= ST_OFF;
               end else if (!start_i) begin
                  state_q <= ST_OFF;
               end else if (grp_ok_i[idx_q]) begin
                  if (idx_q == LAST) state_q <= ST_DONE;
                  else begin
                     idx_q      <= nxt;
                     dis_q[nxt] <= 1'b0;
                     state_q    <= ST_ARM;
                  end
               end else if (tmo_i) begin
                  err_q   <= 1'b1;
                  state_q <= ST_OFF;
               end
            end
            ST_DONE: begin
               if (!(&grp_ok_i)) begin
                  err_q   <= 1'b1;
                  state_q <= ST_OFF;
               end else if (!start_i) begin
                  state_q <= ST_OFF;
               end
            end
            ST_OFF: begin
               on_q[idx_q] <= 1'b0;
               state_q     <= ST_DIS;
            end
            ST_DIS: begin
               dis_q[idx_q] <= 1'b1;
               if (idx_q == '0) state_q <= err_q ? ST_HALT : ST_IDLE;
               else begin
                  idx_q   <= idx_q - GW'(1);
                  state_q <= ST_OFF;
               end
            end
            ST_HALT: ;
            default: state_q <= ST_HALT;
         endcase
      end
   end

   assign grp_on_o   = on_q;
   assign dis_o      = dis_q;
   assign fault_o    = err_q;
   assign all_good_o = (state_q == ST_DONE);
   assign tmr_clr_o  = (state_q == ST_ARM);
   assign tmr_run_o  = (state_q == ST_WAIT);

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
      // R4: enable and discharge of a group never overlap
      a_r4_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
         on_q[g] |-> !dis_q[g]) else $error("R4 enable with discharge");
      // R4: discharge release is followed by the enable one cycle later
      a_r4_release_lead: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $fell(dis_q[g]) |=> on_q[g]) else $error("R4 enable did not follow release");
      // R9: discharge follows the removal of enables by one cycle
      a_r9_dis_after_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $fell(on_q[g]) |=> dis_q[g]) else $error("R9 discharge late");
      if (g > 0) begin : g_ord
         // R3: a group is on only while the one below it is on
         a_r3_chain: assert property (@(posedge clk_i) disable iff (!rst_ni)
            on_q[g] |-> on_q[g-1]) else $error("R3 group order broken");
         // R3: enable follows a good reading of the group below
         a_r3_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(on_q[g]) |-> $past(grp_ok_i[g-1], 2)) else $error("R3 enable not gated");
      end
   end

   // R11: fault never clears without reset
   a_r11_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_q |=> err_q) else $error("R11 fault cleared");
   // R12: all-good only with every group on
   a_r12_good_all_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
      all_good_o |-> &on_q) else $error("R12 all-good with group off");
endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
   import rseq_pkg::*;
#(
   parameter int NUM_GROUPS  = 4,
   parameter int NUM_RAILS   = 9,
   parameter int NUM_PG      = 8,
   parameter logic [NUM_RAILS*MAP_FIELD_W-1:0] RAIL_GROUP_MAP =
      {8'd3, 8'd3, 8'd3, 8'd3, 8'd3, 8'd3, 8'd2, 8'd1, 8'd0},
   parameter logic [NUM_PG*MAP_FIELD_W-1:0] PG_GROUP_MAP =
      {8'd3, 8'd3, 8'd3, 8'd3, 8'd3, 8'd2, 8'd1, 8'd0},
   parameter int TIMEOUT_CYC = 1_250_000
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  start_i,
   input  logic [NUM_PG-1:0]     pg_i,
   output logic [NUM_RAILS-1:0]  rail_en_o,
   output logic [NUM_GROUPS-1:0] dischg_o,
   output logic                  fault_o,
   output logic                  all_good_o
);
   logic [NUM_GROUPS-1:0] grp_ok, grp_on;
   logic                  tmo, tmr_clr, tmr_run;

   rseq_pg_eval #(
      .NUM_GROUPS(NUM_GROUPS), .NUM_PG(NUM_PG), .PG_MAP(PG_GROUP_MAP)
   ) u_pg (
      .pg_i(pg_i), .grp_ok_o(grp_ok)
   );

   rseq_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmr (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(tmr_clr), .run_i(tmr_run),
      .expired_o(tmo)
   );

   rseq_ctrl #(.NUM_GROUPS(NUM_GROUPS)) u_ctrl (
      .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .grp_ok_i(grp_ok),
      .tmo_i(tmo), .grp_on_o(grp_on), .dis_o(dischg_o), .fault_o(fault_o),
      .all_good_o(all_good_o), .tmr_clr_o(tmr_clr), .tmr_run_o(tmr_run)
   );

   rseq_rail_map #(
      .NUM_GROUPS(NUM_GROUPS), .NUM_RAILS(NUM_RAILS), .RAIL_MAP(RAIL_GROUP_MAP)
   ) u_map (
      .grp_on_i(grp_on), .rail_en_o(rail_en_o)
   );
endmodule

// File: tb/rail_sequencer_test.sv
`timescale 1ns/1ps
module rail_sequencer_test;
   localparam int T  = 40;
   localparam int NG = 4;
   localparam int NR = 9;
   localparam int NP = 8;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [NP-1:0] pg = '0;
   logic [NR-1:0] rail_en;
   logic [NG-1:0] dischg;
   logic fault, all_good;

   always #10 clk = ~clk;

   rail_sequencer #(.TIMEOUT_CYC(T)) uut (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pg_i(pg),
      .rail_en_o(rail_en), .dischg_o(dischg), .fault_o(fault), .all_good_o(all_good)
   );

   int n_checks = 0, n_err = 0;
   int pg_rail[NP]   = '{0, 1, 2, 3, 4, 6, 7, 8};
   int pg_grp[NP]    = '{0, 1, 2, 3, 3, 3, 3, 3};
   int grp_first[NG] = '{0, 1, 2, 3};
   int dly[NP];
   int pcnt[NP];
   logic [NP-1:0] force_hi = '0, stuck_lo = '0;

   // rail model: power-good follows its enable after dly negedges
   always @(negedge clk) begin
      for (int i = 0; i < NP; i++) begin
         pcnt[i] = rail_en[pg_rail[i]] ? pcnt[i] + 1 : 0;
         pg[i]   = force_hi[i] | (!stuck_lo[i] && pcnt[i] >= dly[i]);
      end
   end

   // edge marks, recorded just after each rising edge
   int cyc = 0;
   int en_rise[NR], en_fall[NR], dis_fall[NG], dis_rise[NG], pgg_rise[NG];
   int ag_rise, ag_fall, err_rise, st_rise, st_fall, pg_fall;
   logic [NR-1:0] p_en = '0;
   logic [NG-1:0] p_dis = '1, p_gg = '0;
   logic [NP-1:0] p_pg = '0;
   logic p_ag = 0, p_err = 0, p_st = 0;

   always @(posedge clk) begin
      logic [NG-1:0] gg;
      #2;
      cyc++;
      for (int g = 0; g < NG; g++) begin
         gg[g] = 1'b1;
         for (int i = 0; i < NP; i++) if (pg_grp[i] == g && !pg[i]) gg[g] = 1'b0;
      end
      for (int i = 0; i < NR; i++) begin
         if (rail_en[i] && !p_en[i] && en_rise[i] < 0) en_rise[i] = cyc;
         if (!rail_en[i] && p_en[i] && en_fall[i] < 0) en_fall[i] = cyc;
      end
      for (int g = 0; g < NG; g++) begin
         if (!dischg[g] && p_dis[g] && dis_fall[g] < 0) dis_fall[g] = cyc;
         if (dischg[g] && !p_dis[g] && dis_rise[g] < 0) dis_rise[g] = cyc;
         if (gg[g] && !p_gg[g] && pgg_rise[g] < 0) pgg_rise[g] = cyc;
      end
      if (all_good && !p_ag && ag_rise < 0) ag_rise = cyc;
      if (!all_good && p_ag && ag_fall < 0) ag_fall = cyc;
      if (fault && !p_err && err_rise < 0) err_rise = cyc;
      if (start && !p_st && st_rise < 0) st_rise = cyc;
      if (!start && p_st && st_fall < 0) st_fall = cyc;
      if ((p_pg & ~pg) != '0 && pg_fall < 0) pg_fall = cyc;
      p_en = rail_en; p_dis = dischg; p_gg = gg; p_pg = pg;
      p_ag = all_good; p_err = fault; p_st = start;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic clear_marks();
      for (int i = 0; i < NR; i++) begin en_rise[i] = -1; en_fall[i] = -1; end
      for (int g = 0; g < NG; g++) begin
         dis_fall[g] = -1; dis_rise[g] = -1; pgg_rise[g] = -1;
      end
      ag_rise = -1; ag_fall = -1; err_rise = -1;
      st_rise = -1; st_fall = -1; pg_fall = -1;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_settle(input int lim);
      for (int k = 0; k < lim; k++) begin
         @(negedge clk);
         if (all_good || fault) break;
      end
   endtask

   task automatic set_delays(input int d0, d1, d2, d3, d4, d5, d6, d7);
      dly = '{d0, d1, d2, d3, d4, d5, d6, d7};
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; start = 1'b0; force_hi = '0; stuck_lo = '0;
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(1);
      chk(rail_en == '0, "R1 enables", int'(rail_en), 0);
      chk(dischg == '1, "R1 discharge", int'(dischg), 15);
      chk(fault == 1'b0, "R1 fault", int'(fault), 0);
      chk(all_good == 1'b0, "R1 all_good", int'(all_good), 0);
   endtask

   // full power-up and its ordering checks
   task automatic t_powerup(input string tag);
      clear_marks();
      @(negedge clk) start = 1'b1;
      wait_settle(600);
      $display("power-up %s", tag);
      chk(all_good && !fault, "R12 reached all-good", int'(all_good), 1);
      chk(dis_fall[0] == st_rise, "R2 release group 0", dis_fall[0], st_rise);
      chk(en_rise[0] == st_rise + 1, "R2 enable group 0", en_rise[0], st_rise + 1);
      for (int g = 0; g < NG; g++)
         chk(en_rise[grp_first[g]] == dis_fall[g] + 1, "R4 release lead",
             en_rise[grp_first[g]], dis_fall[g] + 1);
      for (int g = 1; g < NG; g++)
         chk(dis_fall[g] == pgg_rise[g-1], "R3 gated on lower group",
             dis_fall[g], pgg_rise[g-1]);
      for (int i = 4; i < NR; i++)
         chk(en_rise[i] == en_rise[3], "R3 group 3 together", en_rise[i], en_rise[3]);
      chk(rail_en[5] == 1'b1, "R5 termination rail on", int'(rail_en[5]), 1);
      chk(ag_rise == pgg_rise[3], "R5 R12 completion edge", ag_rise, pgg_rise[3]);
      chk(rail_en == '1 && dischg == '0, "R12 all rails on",
          int'(rail_en), (1 << NR) - 1);
   endtask

   task automatic chk_reverse(input int s, input int top, input string req);
      for (int g = 0; g <= top; g++) begin
         int k = top - g;
         chk(en_fall[grp_first[g]] == s + 1 + 2*k, req, en_fall[grp_first[g]], s + 1 + 2*k);
         chk(dis_rise[g] == s + 2 + 2*k, req, dis_rise[g], s + 2 + 2*k);
      end
   endtask

   task automatic t_stop();
      clear_marks();
      @(negedge clk) start = 1'b0;
      wait_cyc(20);
      chk(ag_fall == st_fall, "R10 all-good drops on stop", ag_fall, st_fall);
      chk_reverse(st_fall, 3, "R10 R9 reverse on stop");
      for (int i = 4; i < NR; i++)
         chk(en_fall[i] == en_fall[3], "R9 group 3 off together", en_fall[i], en_fall[3]);
      chk(fault == 1'b0, "R10 no fault on stop", int'(fault), 0);
      chk(dischg == '1 && rail_en == '0, "R10 all off", int'(rail_en), 0);
   endtask

   task automatic t_loss();
      clear_marks();
      @(negedge clk) stuck_lo[2] = 1'b1;
      wait_cyc(20);
      chk(err_rise == pg_fall, "R8 fault on lost rail", err_rise, pg_fall);
      chk(ag_fall == pg_fall, "R8 all-good drops", ag_fall, pg_fall);
      chk_reverse(pg_fall, 3, "R9 reverse after loss");
      // R11: start still high, nothing restarts
      wait_cyc(100);
      chk(fault == 1'b1, "R11 fault held", int'(fault), 1);
      chk(rail_en == '0, "R11 rails stay off", int'(rail_en), 0);
      chk(dischg == '1, "R11 discharge held", int'(dischg), 15);
   endtask

   task automatic t_timeout_over();
      clear_marks();
      set_delays(T + 1, 7, 2, 9, 4, 11, 5, 6);
      @(negedge clk) start = 1'b1;
      wait_cyc(T + 20);
      chk(err_rise == en_rise[0] + T, "R7 timeout edge", err_rise, en_rise[0] + T);
      chk(en_rise[1] == -1, "R7 next group never enabled", en_rise[1], -1);
      chk_reverse(err_rise, 0, "R7 R9 shutdown after timeout");
      chk(all_good == 1'b0, "R12 no all-good on fault", int'(all_good), 0);
   endtask

   initial begin
      for (int i = 0; i < NP; i++) pcnt[i] = 0;
      set_delays(3, 7, 2, 9, 4, 11, 5, 6);
      clear_marks();
      do_reset();
      t_powerup("pattern A");
      t_stop();
      wait_cyc(3);
      t_powerup("restart R10");
      t_stop();
      set_delays(9, 2, 6, 1, 8, 3, 12, 4);
      wait_cyc(3);
      t_powerup("pattern B");
      t_loss();
      do_reset();                       // R11 cleared by reset
      // R6: carrier lines read high with no carrier rail response
      force_hi[6] = 1'b1; force_hi[7] = 1'b1;
      set_delays(3, 7, 2, 9, 4, 11, 1000, 1000);
      t_powerup("carrier absent R6");
      chk(ag_rise == pgg_rise[3], "R6 carrier lines do not hold up", ag_rise, pgg_rise[3]);
      do_reset();
      set_delays(T, 7, 2, 9, 4, 11, 5, 6);
      t_powerup("delay equals timeout R7");
      do_reset();
      t_timeout_over();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

   initial begin
      #3_000_000;
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end
endmodule